// File: doc/BRIEF.md
# Load/Store Address Translator with Fault Capture

This block sits between a load/store pipeline and an external page-translation cache. For each request it chooses the privilege mode to check against and validates the virtual address. It either maps the address straight through a kernel-only direct window or sends the virtual page number to the translation cache and builds the physical address from the page frame that comes back. It then checks the per-mode read or write enable and the trap-on-read and trap-on-write bits of the entry. The physical address and a fault code are combinational outputs in the same cycle as the request.

When a request faults, three registers capture the fault. One holds the faulting virtual address. One holds a status word packing the instruction opcode, the destination register number and six cause flags. One holds a formatted entry address built from a page-table base. These registers then lock and ignore later faults until software reads the fault-address register. The translation cache itself, and address-space matching inside it, are outside this block.

Top module: `dtx_translate`

## Requirements
- R1: The check mode is `cur_mode` unless `pc_priv` is high. While `pc_priv` is high, the check mode is `alt_mode` when `req_alt` is high and kernel (0) otherwise. `req_alt` has no effect while `pc_priv` is low. Modes are kernel=0, executive=1, supervisor=2, user=3, and enable bit n of an entry belongs to mode n.
- R2: An address whose bits [47:42] are neither all zero nor all one gives fault code 2 (fault) with flags bad-address and access-violation, plus write for a store.
- R3: With `sp_en` high, a valid address with bits [42:41]=2'b10 bypasses the cache. If `cur_mode` is kernel, `pa` is the address's low 40 bits with fault code 0. Otherwise the fault code is 1 (access violation) with flags access-violation, plus write for a store.
- R4: A cache miss gives fault code 3, or code 4 when `req_pte` is high. Its flags are miss, plus write for a store.
- R5: A permitted hit gives fault code 0 and `pa` = {`tlb_pfn`, va[12:0]}. While `req_valid` is low or any fault is reported, `pa` is zero and the fault code is 0 only when `req_valid` is low.
- R6: A store whose write enable for the check mode is clear gives code 2 with flags write and access-violation, plus trap-on-write if that entry bit is set.
- R7: A store that is write-enabled but has trap-on-write set gives code 2 with flags write and trap-on-write only.
- R8: A load whose read enable for the check mode is clear gives code 1 with flag access-violation, plus trap-on-read if that entry bit is set.
- R9: A read-enabled load with trap-on-read set gives code 2 with flag trap-on-read only.
- R10: The captured status word is {opcode[5:0], ra[4:0], flags[5:0]}, with flag bits write=0, access-violation=1, trap-on-read=2, trap-on-write=3, miss=4, bad-address=5.
- R11: The captured formatted address is `pt_base` OR (virtual page number << 3), where the page number is va[47:13], kept to 48 bits.
- R12: A faulting request captures address, status and formatted registers only while `flt_locked` is low, and sets `flt_locked`. A `fa_rd` pulse while locked clears the lock and leaves the registers unchanged. A fault arriving while locked is dropped.
- R13: After reset `flt_locked` is low and all three fault registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_va | input | 48 | Virtual address |
| req_store | input | 1 | 1 = store, 0 = load |
| req_alt | input | 1 | Use alternate mode while in privileged code |
| req_pte | input | 1 | Request is itself a page-table entry fetch |
| pc_priv | input | 1 | Issuing code runs in privileged code space |
| cur_mode | input | 2 | Current data mode |
| alt_mode | input | 2 | Alternate mode value |
| sp_en | input | 1 | Direct kernel window enabled |
| opcode | input | 6 | Opcode of issuing instruction |
| ra | input | 5 | Register number of issuing instruction |
| pt_base | input | 48 | Page-table base for formatted address |
| tlb_vpn | output | 35 | Page number sent to the translation cache |
| tlb_hit | input | 1 | Cache hit |
| tlb_pfn | input | 27 | Page frame number of hit |
| tlb_rd_en | input | 4 | Per-mode read enables |
| tlb_wr_en | input | 4 | Per-mode write enables |
| tlb_for | input | 1 | Trap-on-read bit |
| tlb_fow | input | 1 | Trap-on-write bit |
| fa_rd | input | 1 | Software reads the fault-address register |
| pa | output | 40 | Physical address |
| fault | output | 3 | 0 none, 1 access violation, 2 fault, 3 miss, 4 entry-fetch miss |
| flt_va | output | 48 | Captured faulting address |
| flt_stat | output | 17 | Captured status word |
| flt_form | output | 48 | Captured formatted entry address |
| flt_locked | output | 1 | Fault registers locked |

## Verification
The bench targets the ordering of permission checks. A store that is write-disabled and also has trap-on-write set must report both causes under the fault code. A design that tested trap-on-write first would drop the access-violation flag. A design that swapped load and store enables would pass stores with only read permission. Mode selection is probed with the alternate flag set outside privileged code, where a design honouring it would grant access. The lock is exercised by sending a second fault, and a fault together with a read, while locked. A design that re-captured would overwrite the first address, and one that handled capture before unlock would lose the read.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
   typedef enum logic [1:0] {
      MODE_KERN = 2'd0,
      MODE_EXEC = 2'd1,
      MODE_SUPV = 2'd2,
      MODE_USER = 2'd3
   } mode_e;

   typedef enum logic [2:0] {
      FC_NONE    = 3'd0,
      FC_ACV     = 3'd1,
      FC_FAULT   = 3'd2,
      FC_MISS    = 3'd3,
      FC_PTEMISS = 3'd4
   } fcode_e;

   localparam int FLAG_W    = 6;
   localparam int FB_WRITE  = 0;
   localparam int FB_ACV    = 1;
   localparam int FB_TRD    = 2;
   localparam int FB_TWR    = 3;
   localparam int FB_MISS   = 4;
   localparam int FB_BADVA  = 5;
endpackage

// File: rtl/dtx_mode_sel.sv
module dtx_mode_sel
   import dtx_pkg::*;
(
   input  logic       pc_priv,
   input  logic       req_alt,
   input  logic [1:0] cur_mode,
   input  logic [1:0] alt_mode,
   output logic [1:0] eff_mode
);
   always_comb begin
      if (!pc_priv)     eff_mode = cur_mode;
      else if (req_alt) eff_mode = alt_mode;
      else              eff_mode = MODE_KERN;
   end
endmodule

// File: rtl/dtx_classify.sv
module dtx_classify
   import dtx_pkg::*;
#(
   parameter int  VA_W      = 48,
   parameter int  VA_IMPL   = 43,
   parameter int  PA_W      = 40,
   parameter int  PAGE_BITS = 13,
   parameter bit  SP_IMPL   = 1'b1,
   localparam int PFN_W     = PA_W - PAGE_BITS
)(
   input  logic [VA_W-1:0]   va,
   input  logic              store,
   input  logic              pte,
   input  logic              sp_en,
   input  logic [1:0]        cur_mode,
   input  logic [1:0]        eff_mode,
   input  logic              hit,
   input  logic [PFN_W-1:0]  pfn,
   input  logic [3:0]        rd_en,
   input  logic [3:0]        wr_en,
   input  logic              trap_rd,
   input  logic              trap_wr,
   output fcode_e            code,
   output logic [FLAG_W-1:0] flags,
   output logic [PA_W-1:0]   pa
);
   localparam int HI_W = VA_W - VA_IMPL + 1;

   logic [HI_W-1:0] hi_bits;
   logic            va_ok;
   logic            sp_hit;
   logic [PA_W-1:0] mapped_pa;

   assign hi_bits   = va[VA_W-1:VA_IMPL-1];
   assign va_ok     = (&hi_bits) | ~(|hi_bits);
   assign mapped_pa = {pfn, va[PAGE_BITS-1:0]};

   generate
      if (SP_IMPL) begin : g_sp
         assign sp_hit = sp_en && (va[VA_IMPL-1:VA_IMPL-2] == 2'b10);
      end else begin : g_nosp
         assign sp_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      code  = FC_NONE;
      flags = '0;
      pa    = '0;
      flags[FB_WRITE] = store;
      if (!va_ok) begin
         code             = FC_FAULT;
         flags[FB_BADVA]  = 1'b1;
         flags[FB_ACV]    = 1'b1;
      end else if (sp_hit) begin
         if (cur_mode != MODE_KERN) begin
            code          = FC_ACV;
            flags[FB_ACV] = 1'b1;
         end else begin
            pa = va[PA_W-1:0];
         end
      end else if (!hit) begin
         code           = pte ? FC_PTEMISS : FC_MISS;
         flags[FB_MISS] = 1'b1;
      end else if (store) begin
         if (!wr_en[eff_mode]) begin
            code          = FC_FAULT;
            flags[FB_ACV] = 1'b1;
            flags[FB_TWR] = trap_wr;
         end else if (trap_wr) begin
            code          = FC_FAULT;
            flags[FB_TWR] = 1'b1;
         end else begin
            pa = mapped_pa;
         end
      end else begin
         if (!rd_en[eff_mode]) begin
            code          = FC_ACV;
            flags[FB_ACV] = 1'b1;
            flags[FB_TRD] = trap_rd;
         end else if (trap_rd) begin
            code          = FC_FAULT;
            flags[FB_TRD] = 1'b1;
         end else begin
            pa = mapped_pa;
         end
      end
      if (code == FC_NONE) flags = '0;
   end
endmodule

// File: rtl/dtx_fault_regs.sv
module dtx_fault_regs
   import dtx_pkg::*;
#(
   parameter int  VA_W   = 48,
   parameter int  STAT_W = 17
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic              rd,
   input  logic [VA_W-1:0]   va_in,
   input  logic [STAT_W-1:0] stat_in,
   input  logic [VA_W-1:0]   form_in,
   output logic [VA_W-1:0]   va_q,
   output logic [STAT_W-1:0] stat_q,
   output logic [VA_W-1:0]   form_q,
   output logic              locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         va_q   <= '0;
         stat_q <= '0;
         form_q <= '0;
         locked <= 1'b0;
      end else if (locked) begin
         if (rd) locked <= 1'b0;
      end else if (capture) begin
         va_q   <= va_in;
         stat_q <= stat_in;
         form_q <= form_in;
         locked <= 1'b1;
      end
   end
endmodule

// File: rtl/dtx_translate.sv
module dtx_translate
   import dtx_pkg::*;
#(
   parameter int  VA_W      = 48,
   parameter int  VA_IMPL   = 43,
   parameter int  PA_W      = 40,
   parameter int  PAGE_BITS = 13,
   parameter int  OPC_W     = 6,
   parameter int  RA_W      = 5,
   parameter bit  SP_IMPL   = 1'b1,
   localparam int VPN_W     = VA_W - PAGE_BITS,
   localparam int PFN_W     = PA_W - PAGE_BITS,
   localparam int STAT_W    = OPC_W + RA_W + FLAG_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VA_W-1:0]   req_va,
   input  logic              req_store,
   input  logic              req_alt,
   input  logic              req_pte,
   input  logic              pc_priv,
   input  logic [1:0]        cur_mode,
   input  logic [1:0]        alt_mode,
   input  logic              sp_en,
   input  logic [OPC_W-1:0]  opcode,
   input  logic [RA_W-1:0]   ra,
   input  logic [VA_W-1:0]   pt_base,
   output logic [VPN_W-1:0]  tlb_vpn,
   input  logic              tlb_hit,
   input  logic [PFN_W-1:0]  tlb_pfn,
   input  logic [3:0]        tlb_rd_en,
   input  logic [3:0]        tlb_wr_en,
   input  logic              tlb_for,
   input  logic              tlb_fow,
   input  logic              fa_rd,
   output logic [PA_W-1:0]   pa,
   output logic [2:0]        fault,
   output logic [VA_W-1:0]   flt_va,
   output logic [STAT_W-1:0] flt_stat,
   output logic [VA_W-1:0]   flt_form,
   output logic              flt_locked
);
   generate
      if (PA_W <= PAGE_BITS)        begin : g_bad_pa  $error("PA_W must exceed PAGE_BITS"); end
      if (VA_IMPL > VA_W)           begin : g_bad_va  $error("VA_IMPL must not exceed VA_W"); end
      if (PA_W > VA_IMPL - 2)       begin : g_bad_sp  $error("PA_W must sit below the window bits"); end
      if (OPC_W != 6 || RA_W != 5)  begin : g_bad_stw $error("status word layout needs 6+5 bits"); end
   endgenerate

   logic [1:0]        eff_mode;
   fcode_e            code;
   logic [FLAG_W-1:0] flags;
   logic [PA_W-1:0]   pa_raw;
   logic [VA_W-1:0]   form;
   logic              capture;

   assign tlb_vpn = req_va[VA_W-1:PAGE_BITS];

   dtx_mode_sel u_mode (
      .pc_priv  (pc_priv),
      .req_alt  (req_alt),
      .cur_mode (cur_mode),
      .alt_mode (alt_mode),
      .eff_mode (eff_mode)
   );

   dtx_classify #(
      .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W),
      .PAGE_BITS(PAGE_BITS), .SP_IMPL(SP_IMPL)
   ) u_cls (
      .va       (req_va),
      .store    (req_store),
      .pte      (req_pte),
      .sp_en    (sp_en),
      .cur_mode (cur_mode),
      .eff_mode (eff_mode),
      .hit      (tlb_hit),
      .pfn      (tlb_pfn),
      .rd_en    (tlb_rd_en),
      .wr_en    (tlb_wr_en),
      .trap_rd  (tlb_for),
      .trap_wr  (tlb_fow),
      .code     (code),
      .flags    (flags),
      .pa       (pa_raw)
   );

   assign fault   = req_valid ? code : FC_NONE;
   assign pa      = req_valid ? pa_raw : '0;
   assign capture = req_valid && (code != FC_NONE);
   assign form    = pt_base | (VA_W'(tlb_vpn) << 3);

   dtx_fault_regs #(.VA_W(VA_W), .STAT_W(STAT_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (capture),
      .rd      (fa_rd),
      .va_in   (req_va),
      .stat_in ({opcode, ra, flags}),
      .form_in (form),
      .va_q    (flt_va),
      .stat_q  (flt_stat),
      .form_q  (flt_form),
      .locked  (flt_locked)
   );
endmodule

// File: rtl/dtx_translate_chk.sv
module dtx_translate_chk #(
   parameter int VA_W    = 48,
   parameter int VA_IMPL = 43,
   parameter int PA_W    = 40,
   parameter int STAT_W  = 17
)(
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [VA_W-1:0]   req_va,
   input logic              req_store,
   input logic              req_pte,
   input logic              sp_en,
   input logic              tlb_hit,
   input logic [5:0]        opcode,
   input logic              fa_rd,
   input logic [PA_W-1:0]   pa,
   input logic [2:0]        fault,
   input logic [VA_W-1:0]   flt_va,
   input logic [STAT_W-1:0] flt_stat,
   input logic [VA_W-1:0]   flt_form,
   input logic              flt_locked
);
   logic hi_ok;
   logic in_win;
   assign hi_ok  = (&req_va[VA_W-1:VA_IMPL-1]) | ~(|req_va[VA_W-1:VA_IMPL-1]);
   assign in_win = sp_en && (req_va[VA_IMPL-1:VA_IMPL-2] == 2'b10);

   a_r2_bad_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hi_ok) |-> (fault == 3'd2));

   a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && hi_ok && !in_win && !tlb_hit) |-> (fault == (req_pte ? 3'd4 : 3'd3)));

   a_r5_pa_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 3'd0) |-> (pa == '0));

   a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_locked && !fa_rd) |=> (flt_locked && $stable(flt_va) && $stable(flt_stat) && $stable(flt_form)));

   a_r12_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt_locked && req_valid && fault != 3'd0) |=> (flt_locked && flt_va == $past(req_va)));

   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flt_locked && fa_rd) |=> (!flt_locked && $stable(flt_va)));

   a_r10_opcode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_locked) |-> (flt_stat[STAT_W-1:STAT_W-6] == $past(opcode)));

   a_r10_write_flag: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flt_locked) |-> (flt_stat[0] == $past(req_store)));
endmodule

bind dtx_translate dtx_translate_chk #(
   .VA_W(VA_W), .VA_IMPL(VA_IMPL), .PA_W(PA_W), .STAT_W(STAT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
   .req_store(req_store), .req_pte(req_pte), .sp_en(sp_en), .tlb_hit(tlb_hit),
   .opcode(opcode), .fa_rd(fa_rd), .pa(pa), .fault(fault), .flt_va(flt_va),
   .flt_stat(flt_stat), .flt_form(flt_form), .flt_locked(flt_locked)
);

// File: tb/dtx_translate_test.sv
module dtx_translate_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [3:0]  rq;
      logic        st, alt, priv, pte, spen;
      logic [1:0]  cm, am;
      logic [47:0] va;
      logic        hit;
      logic [26:0] pfn;
      logic [3:0]  rd, wr;
      logic        fr, fw;
      logic [2:0]  code;
      logic [5:0]  flg;
      logic [39:0] pa;
   } vec_t;

   localparam logic [47:0] VA_N  = 48'h0000_1234_5ABC;
   localparam logic [47:0] VA_B  = 48'h0800_0000_0000;
   localparam logic [47:0] VA_S  = 48'hFC12_3456_7890;
   localparam logic [26:0] PF    = 27'h00ABCDE;
   localparam logic [39:0] PA_N  = {27'h00ABCDE, 13'h1ABC};
   localparam logic [39:0] PA_SN = {27'h00ABCDE, 13'h1890};
   localparam int NV = 19;

   localparam vec_t TBL [NV] = '{
      // rq  st  alt pri pte sp  cm     am     va    hit pfn rd       wr       fr  fw  code  flg    pa
      '{4'd5,1'b0,1'b0,1'b0,1'b0,1'b1,2'd3,2'd0,VA_N,1'b1,PF,4'b1000,4'b0000,1'b0,1'b0,3'd0,6'h00,PA_N},  // R5 load ok
      '{4'd5,1'b1,1'b0,1'b0,1'b0,1'b1,2'd3,2'd0,VA_N,1'b1,PF,4'b0000,4'b1000,1'b0,1'b0,3'd0,6'h00,PA_N},  // R5 store ok
      '{4'd8,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b0111,4'b1111,1'b0,1'b0,3'd1,6'h02,40'h0}, // R8
      '{4'd8,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b0111,4'b1111,1'b1,1'b0,3'd1,6'h06,40'h0}, // R8 +trap
      '{4'd9,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b1000,4'b0000,1'b1,1'b0,3'd2,6'h04,40'h0}, // R9
      '{4'd6,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b1111,4'b0111,1'b0,1'b1,3'd2,6'h0B,40'h0}, // R6 +trap
      '{4'd7,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b0000,4'b1000,1'b0,1'b1,3'd2,6'h09,40'h0}, // R7
      '{4'd6,1'b1,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b1111,4'b0111,1'b0,1'b0,3'd2,6'h03,40'h0}, // R6
      '{4'd4,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b0,PF,4'b1111,4'b1111,1'b0,1'b0,3'd3,6'h10,40'h0}, // R4
      '{4'd4,1'b1,1'b0,1'b0,1'b1,1'b0,2'd3,2'd0,VA_N,1'b0,PF,4'b1111,4'b1111,1'b0,1'b0,3'd4,6'h11,40'h0}, // R4 entry fetch
      '{4'd2,1'b1,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,VA_B,1'b1,PF,4'b1111,4'b1111,1'b0,1'b0,3'd2,6'h23,40'h0}, // R2 store
      '{4'd2,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,VA_B,1'b1,PF,4'b1111,4'b1111,1'b0,1'b0,3'd2,6'h22,40'h0}, // R2 load
      '{4'd3,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,2'd0,VA_S,1'b0,PF,4'b0000,4'b0000,1'b0,1'b0,3'd0,6'h00,40'h12_3456_7890}, // R3 kernel
      '{4'd3,1'b1,1'b0,1'b0,1'b0,1'b1,2'd3,2'd0,VA_S,1'b1,PF,4'b1111,4'b1111,1'b0,1'b0,3'd1,6'h03,40'h0}, // R3 user
      '{4'd3,1'b0,1'b0,1'b0,1'b0,1'b0,2'd3,2'd0,VA_S,1'b1,PF,4'b1000,4'b0000,1'b0,1'b0,3'd0,6'h00,PA_SN}, // R3 window off
      '{4'd1,1'b0,1'b0,1'b1,1'b0,1'b0,2'd3,2'd2,VA_N,1'b1,PF,4'b0001,4'b0000,1'b0,1'b0,3'd0,6'h00,PA_N},  // R1 priv->kernel
      '{4'd1,1'b0,1'b1,1'b1,1'b0,1'b0,2'd3,2'd2,VA_N,1'b1,PF,4'b0100,4'b0000,1'b0,1'b0,3'd0,6'h00,PA_N},  // R1 alt mode
      '{4'd1,1'b0,1'b1,1'b1,1'b0,1'b0,2'd0,2'd2,VA_N,1'b1,PF,4'b0001,4'b0000,1'b0,1'b0,3'd1,6'h02,40'h0}, // R1 alt denies
      '{4'd1,1'b0,1'b1,1'b0,1'b0,1'b0,2'd3,2'd0,VA_N,1'b1,PF,4'b0001,4'b0000,1'b0,1'b0,3'd1,6'h02,40'h0}  // R1 alt ignored
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_store = 1'b0, req_alt = 1'b0, req_pte = 1'b0;
   logic        pc_priv = 1'b0, sp_en = 1'b0;
   logic [47:0] req_va = '0, pt_base = '0;
   logic [1:0]  cur_mode = '0, alt_mode = '0;
   logic [5:0]  opcode = '0;
   logic [4:0]  ra = '0;
   logic [34:0] tlb_vpn;
   logic        tlb_hit = 1'b0, tlb_for = 1'b0, tlb_fow = 1'b0, fa_rd = 1'b0;
   logic [26:0] tlb_pfn = '0;
   logic [3:0]  tlb_rd_en = '0, tlb_wr_en = '0;
   logic [39:0] pa;
   logic [2:0]  fault;
   logic [47:0] flt_va, flt_form;
   logic [16:0] flt_stat;
   logic        flt_locked;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dtx_translate uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
      .req_store(req_store), .req_alt(req_alt), .req_pte(req_pte), .pc_priv(pc_priv),
      .cur_mode(cur_mode), .alt_mode(alt_mode), .sp_en(sp_en), .opcode(opcode), .ra(ra),
      .pt_base(pt_base), .tlb_vpn(tlb_vpn), .tlb_hit(tlb_hit), .tlb_pfn(tlb_pfn),
      .tlb_rd_en(tlb_rd_en), .tlb_wr_en(tlb_wr_en), .tlb_for(tlb_for), .tlb_fow(tlb_fow),
      .fa_rd(fa_rd), .pa(pa), .fault(fault), .flt_va(flt_va), .flt_stat(flt_stat),
      .flt_form(flt_form), .flt_locked(flt_locked)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic drive(input vec_t v, input logic [5:0] op, input logic [4:0] r);
      req_valid = 1'b1; req_store = v.st; req_alt = v.alt; pc_priv = v.priv;
      req_pte = v.pte; sp_en = v.spen; cur_mode = v.cm; alt_mode = v.am;
      req_va = v.va; tlb_hit = v.hit; tlb_pfn = v.pfn; tlb_rd_en = v.rd;
      tlb_wr_en = v.wr; tlb_for = v.fr; tlb_fow = v.fw; opcode = op; ra = r;
   endtask

   task automatic unlock();
      @(negedge clk);
      req_valid = 1'b0; fa_rd = 1'b1;
      @(negedge clk);
      fa_rd = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      pt_base = 48'h0000_8000_0000;
      repeat (3) @(negedge clk);
      // R13 reset state
      chk(flt_locked == 1'b0, "R13", "locked", 64'(flt_locked), 64'd0);
      chk(flt_va == '0 && flt_stat == '0 && flt_form == '0, "R13", "regs", 64'(flt_stat), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 idle gives no fault
      chk(fault == 3'd0 && pa == '0, "R5", "idle", 64'(fault), 64'd0);

      for (int i = 0; i < NV; i++) begin
         logic [5:0] op;
         logic [4:0] r;
         string tag;
         op = 6'(i * 5 + 3);
         r  = 5'(i * 3 + 1);
         tag = $sformatf("R%0d", TBL[i].rq);
         @(negedge clk);
         drive(TBL[i], op, r);
         #1;
         chk(fault == TBL[i].code, tag, $sformatf("vec%0d code", i), 64'(fault), 64'(TBL[i].code));
         chk(pa == TBL[i].pa, tag, $sformatf("vec%0d pa", i), 64'(pa), 64'(TBL[i].pa));
         @(posedge clk); #1;
         if (TBL[i].code != 3'd0) begin
            // R10 status packing, R12 capture
            chk(flt_locked, "R12", $sformatf("vec%0d lock", i), 64'(flt_locked), 64'd1);
            chk(flt_stat == {op, r, TBL[i].flg}, "R10", $sformatf("vec%0d stat", i),
                64'(flt_stat), 64'({op, r, TBL[i].flg}));
            unlock();
         end else begin
            chk(!flt_locked, "R12", $sformatf("vec%0d no capture", i), 64'(flt_locked), 64'd0);
         end
      end

      // R11 formatted address and R12 locking sequence
      @(negedge clk);
      drive(TBL[8], 6'h2A, 5'h11);
      @(posedge clk); #1;
      chk(flt_va == VA_N, "R12", "first va", 64'(flt_va), 64'(VA_N));
      chk(flt_form == (48'h0000_8000_0000 | ((VA_N >> 13) << 3)), "R11", "form",
          64'(flt_form), 64'(48'h0000_8000_0000 | ((VA_N >> 13) << 3)));
      @(negedge clk);
      drive(TBL[10], 6'h15, 5'h02);
      @(posedge clk); #1;
      chk(flt_va == VA_N, "R12", "locked keeps va", 64'(flt_va), 64'(VA_N));
      chk(flt_stat == {6'h2A, 5'h11, 6'h10}, "R12", "locked keeps stat",
          64'(flt_stat), 64'({6'h2A, 5'h11, 6'h10}));
      @(negedge clk);
      fa_rd = 1'b1;
      @(posedge clk); #1;
      chk(!flt_locked, "R12", "read clears lock", 64'(flt_locked), 64'd0);
      chk(flt_va == VA_N, "R12", "read with fault keeps va", 64'(flt_va), 64'(VA_N));
      @(negedge clk);
      fa_rd = 1'b0;
      @(posedge clk); #1;
      chk(flt_locked && flt_va == VA_B, "R12", "recapture after unlock", 64'(flt_va), 64'(VA_B));
      chk(flt_stat == {6'h15, 5'h02, 6'h23}, "R2", "bad addr stat",
          64'(flt_stat), 64'({6'h15, 5'h02, 6'h23}));
      unlock();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule